// File: doc/BRIEF.md
# Reversible-Gate Ripple-Carry Adder

This block adds two unsigned operands of a parameterised width and returns a result one bit wider. It is the partial-product summing element of a multiplier whose cells are built from reversible logic. Each bit position is one reversible gate. The carry leaves each position and enters the next higher one, so the carry path runs once through the whole width.

Position zero never receives a carry. It is therefore a three-line reversible half-adder gate, with its control input tied low. Every higher position is a four-line reversible full-adder gate, with its fourth line tied low so that this line carries the carry-out.

The reversible gates also produce outputs that the addition does not use. These appear on two garbage ports, and the surrounding logic leaves them unconnected. The multiplier uses copies of this block at widths 4, 5, 8 and 9. The block is purely combinational.

Top module: `rev_ripple_adder`

## Requirements
- R1: For every pair of operands, `sum` equals the unsigned sum `opa + opb`, taken over all WIDTH+1 bits.
- R2: `sum[0]` equals `opa[0] ^ opb[0]` in every case. No carry enters the lowest position.
- R3: `sum[WIDTH]` is 1 exactly when `opa + opb` is at least 2^WIDTH.
- R4: Each bit `i` of `garb_a` (bits 0 to WIDTH-1) equals `opa[i]`.
- R5: Each bit `i-1` of `garb_b` (for `i` from 1 to WIDTH-1) equals `opb[i]`. The lowest position adds no bit to `garb_b`.
- R6: When `opb` is zero, `sum` equals `opa` with a 0 as its top bit.
- R7: When `opa` is all ones and `opb` is 1, the carry ripples through every position. `sum` is then 1 in bit WIDTH and 0 in every lower bit.
- R8: R1 holds at each of the widths 4, 5, 8 and 9, which are built from the same source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH+1 | Unsigned sum; the top bit is the final carry |
| garb_a | output | WIDTH | Garbage lines that copy the first operand, one per position |
| garb_b | output | WIDTH-1 | Garbage lines that copy the second operand, positions 1 and up |

## Verification
The bench builds four copies of the adder, at widths 4, 5, 8 and 9. It drives all four copies from different slices of one 18-bit counter. Stepping that counter once through its range applies every operand pair to each width, the 9-bit case included. This exhaustive sweep reaches every carry pattern: the full ripple from position zero to the top, the sums that just cross 2^WIDTH, and the zero operand. The sweep also shows that a position-zero half adder and full adders above it give the same arithmetic at both odd and even widths.

// File: rtl/rev_add_pkg.sv
package rev_add_pkg;

    // Constant line tied to the unused inputs of reversible gates
    localparam logic TIE_LOW = 1'b0;

    // Four-line reversible full-adder gate outputs
    typedef struct packed {
        logic p;   // copy of a
        logic q;   // copy of b
        logic r;   // a ^ b ^ c
        logic s;   // majority-style carry, xor d
    } hng_lines_t;

    // Three-line reversible half-adder gate outputs
    typedef struct packed {
        logic p;   // copy of a
        logic q;   // a ^ b
        logic r;   // (a & b) ^ c
    } peres_lines_t;

    function automatic hng_lines_t hng_map(logic a, logic b, logic c, logic d);
        hng_lines_t o;
        o.p = a;
        o.q = b;
        o.r = a ^ b ^ c;
        o.s = ((a ^ b) & c) ^ (a & b) ^ d;
        return o;
    endfunction

    function automatic peres_lines_t peres_map(logic a, logic b, logic c);
        peres_lines_t o;
        o.p = a;
        o.q = a ^ b;
        o.r = (a & b) ^ c;
        return o;
    endfunction

endpackage

// File: rtl/rev_hng_cell.sv
module rev_hng_cell
    import rev_add_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       c,
    input  logic       d,
    output hng_lines_t y
);
    always_comb begin
        y = hng_map(a, b, c, d);
    end
endmodule

// File: rtl/rev_peres_cell.sv
module rev_peres_cell
    import rev_add_pkg::*;
(
    input  logic         a,
    input  logic         b,
    input  logic         c,
    output peres_lines_t y
);
    always_comb begin
        y = peres_map(a, b, c);
    end
endmodule

// File: rtl/rev_ripple_adder.sv
module rev_ripple_adder
    import rev_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH:0]   sum,
    output logic [WIDTH-1:0] garb_a,
    output logic [WIDTH-2:0] garb_b
);
    localparam int TOP_POS = WIDTH - 1;

    // chain[k] is the carry entering position k
    logic [WIDTH:1] chain;
    peres_lines_t   lsb_lines;

    // Position 0: half adder, carry-in fixed low
    rev_peres_cell u_lsb (
        .a (opa[0]),
        .b (opb[0]),
        .c (TIE_LOW),
        .y (lsb_lines)
    );

    assign sum[0]    = lsb_lines.q;
    assign chain[1]  = lsb_lines.r;
    assign garb_a[0] = lsb_lines.p;

    // Positions 1..TOP_POS: full adders, fourth line tied low
    for (genvar g = 1; g <= TOP_POS; g++) begin : g_pos
        hng_lines_t fa_lines;

        rev_hng_cell u_fa (
            .a (opa[g]),
            .b (opb[g]),
            .c (chain[g]),
            .d (TIE_LOW),
            .y (fa_lines)
        );

        assign sum[g]       = fa_lines.r;
        assign chain[g+1]   = fa_lines.s;
        assign garb_a[g]    = fa_lines.p;
        assign garb_b[g-1]  = fa_lines.q;
    end

    assign sum[WIDTH] = chain[WIDTH];

endmodule

// File: rtl/rev_ripple_adder_chk.sv
module rev_ripple_adder_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH:0]   sum,
    input logic [WIDTH-1:0] garb_a,
    input logic [WIDTH-2:0] garb_b
);
    logic [WIDTH:0] ref_total;
    logic [WIDTH:0] full_ripple;

    always_comb begin
        ref_total   = {1'b0, opa} + {1'b0, opb};
        full_ripple = '0;
        full_ripple[WIDTH] = 1'b1;
    end

    always_comb begin
        if (!$isunknown({opa, opb})) begin
            AST_SUM_EXACT: assert (sum == ref_total) else $error("sum mismatch");                                   // R1
            AST_LSB_HALF: assert (sum[0] == (opa[0] ^ opb[0])) else $error("lsb not half sum");                   // R2
            AST_PASS_A: assert (garb_a == opa) else $error("garbage a mismatch");                                 // R4
            AST_PASS_B: assert (garb_b == opb[WIDTH-1:1]) else $error("garbage b mismatch");                      // R5
            if (opb == '0) begin
                AST_ZERO_ADDEND: assert (sum == {1'b0, opa}) else $error("zero addend changed result");          // R6
            end
            if ((&opa) && (opb == {{(WIDTH-1){1'b0}}, 1'b1})) begin
                AST_FULL_RIPPLE: assert (sum == full_ripple) else $error("carry did not ripple");                // R7
            end
        end
    end
endmodule

bind rev_ripple_adder rev_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .opa    (opa),
    .opb    (opb),
    .sum    (sum),
    .garb_a (garb_a),
    .garb_b (garb_b)
);

// File: tb/rev_ripple_adder_tb.sv
module rev_ripple_adder_tb;

    typedef struct {
        logic [17:0] vec;
        logic [4:0]  e4;
        logic [5:0]  e5;
        logic [8:0]  e8;
        logic [9:0]  e9;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [3:0] a4, b4;  logic [4:0] s4;  logic [3:0] ga4;  logic [2:0] gb4;
    logic [4:0] a5, b5;  logic [5:0] s5;  logic [4:0] ga5;  logic [3:0] gb5;
    logic [7:0] a8, b8;  logic [8:0] s8;  logic [7:0] ga8;  logic [6:0] gb8;
    logic [8:0] a9, b9;  logic [9:0] s9;  logic [8:0] ga9;  logic [7:0] gb9;

    rev_ripple_adder #(.WIDTH(8)) u_dut  (.opa(a8), .opb(b8), .sum(s8), .garb_a(ga8), .garb_b(gb8));
    rev_ripple_adder #(.WIDTH(4)) u_dut4 (.opa(a4), .opb(b4), .sum(s4), .garb_a(ga4), .garb_b(gb4));
    rev_ripple_adder #(.WIDTH(5)) u_dut5 (.opa(a5), .opb(b5), .sum(s5), .garb_a(ga5), .garb_b(gb5));
    rev_ripple_adder #(.WIDTH(9)) u_dut9 (.opa(a9), .opb(b9), .sum(s9), .garb_a(ga9), .garb_b(gb9));

    sb_item_t sb_q[$];
    event     drv_ev;
    int       total = 0;
    int       bad = 0;
    int       cyc = 0;
    bit       reported = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic apply(logic [17:0] v);
        sb_item_t it;
        a9 = v[17:9]; b9 = v[8:0];
        a8 = v[15:8]; b8 = v[7:0];
        a5 = v[9:5];  b5 = v[4:0];
        a4 = v[7:4];  b4 = v[3:0];
        it.vec = v;
        it.e9 = 10'(v[17:9]) + 10'(v[8:0]);
        it.e8 = 9'(v[15:8])  + 9'(v[7:0]);
        it.e5 = 6'(v[9:5])   + 6'(v[4:0]);
        it.e4 = 5'(v[7:4])   + 5'(v[3:0]);
        sb_q.push_back(it);
        -> drv_ev;
        #5;
    endtask

    // Monitor: pops one expected item per applied vector
    initial begin
        forever begin
            sb_item_t it;
            @(drv_ev);
            #1;
            it = sb_q.pop_front();
            // R1 / R8: full sum at each width
            chk("R1 w4", 32'(s4), 32'(it.e4));
            chk("R1 w5", 32'(s5), 32'(it.e5));
            chk("R1 w8", 32'(s8), 32'(it.e8));
            chk("R8 w9", 32'(s9), 32'(it.e9));
            // R2: lowest bit is the plain xor
            chk("R2 w9", 32'(s9[0]), 32'(it.vec[9] ^ it.vec[0]));
            chk("R2 w4", 32'(s4[0]), 32'(it.vec[4] ^ it.vec[0]));
            // R3: top bit set iff sum reaches 2^WIDTH
            chk("R3 w8", 32'(s8[8]), 32'((32'(it.vec[15:8]) + 32'(it.vec[7:0])) >= 256));
            chk("R3 w5", 32'(s5[5]), 32'((32'(it.vec[9:5]) + 32'(it.vec[4:0])) >= 32));
            // R4 / R5: garbage lines copy the operands
            chk("R4 w9", 32'(ga9), 32'(it.vec[17:9]));
            chk("R5 w9", 32'(gb9), 32'(it.vec[8:1]));
            chk("R5 w4", 32'(gb4), 32'(it.vec[3:1]));
            // R6: zero second operand
            if (it.vec[7:0] == 8'd0) chk("R6 w8", 32'(s8), 32'(it.vec[15:8]));
            // R7: full ripple through every position
            if (it.vec[15:8] == 8'hFF && it.vec[7:0] == 8'd1) chk("R7 w8", 32'(s8), 32'h100);
            if (it.vec[17:9] == 9'h1FF && it.vec[8:0] == 9'd1) chk("R7 w9", 32'(s9), 32'h200);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            report();
        end
    end

    // Driver
    initial begin
        a4 = '0; b4 = '0; a5 = '0; b5 = '0;
        a8 = '0; b8 = '0; a9 = '0; b9 = '0;
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Initial state with zero operands (R6)
        chk("R6 idle w8", 32'(s8), 32'd0);
        chk("R6 idle w9", 32'(s9), 32'd0);
        for (int v = 0; v < (1 << 18); v++) begin
            apply(18'(v));
        end
        #10;
        chk("R1 queue drained", 32'(sb_q.size()), 32'd0);
        report();
    end

endmodule